// File: doc/BRIEF.md
# Power-Mode Clock Controller

This block decides, cycle by cycle, which clocks of a small microcontroller are allowed to tick. It runs from the oscillator clock and watches four kinds of request from the core and its surroundings. The first is a slow-rate select bit. The second and third are one-cycle strobes that ask for the wait or the halt state. The last group is the wake-up sources: an external interrupt, an internal peripheral interrupt and a functional reset request. From these it drives registered enables for the CPU clock gate, the peripheral clock gate and the oscillator. It also drives a level that forces the core's interrupt mask to zero.

In the run state both clock enables are high every cycle, or every other cycle when the slow bit is set. Wait stops only the CPU. Halt stops the oscillator and both clocks. Leaving halt takes a fixed stabilization count before the clocks come back. On every return to run the block pulses a resume flag. A companion bit tells the core whether to fetch the reset vector or to service an interrupt. The core's datapath, its stack handling and its vector table are outside this block.

Top module: `pmcc_top`

## Requirements
- R1: After the asynchronous reset, and in the run state with the slow bit clear, `cpu_clk_en_o`, `per_clk_en_o` and `osc_en_o` are 1 on every cycle. `imask_clr_o`, `resume_o` and `resume_reset_o` are 0.
- R2: In the run state with `slow_sel_i` = 1, the two clock enables are equal and are 1 on exactly every other cycle. No two consecutive cycles have the CPU enable high.
- R3: One cycle after `wfi_i` is sampled in run, `cpu_clk_en_o` = 0, `osc_en_o` = 1 and `imask_clr_o` = 1. `per_clk_en_o` keeps ticking at the selected rate. This holds until a wake source arrives.
- R4: In wait, any of `ext_irq_i`, `int_irq_i` or `sys_reset_i` returns the block to run one cycle later. `resume_o` is then high for exactly one cycle. `resume_reset_o` = 1 only if `sys_reset_i` was the cause.
- R5: One cycle after `halt_i` is sampled in run, `osc_en_o`, `cpu_clk_en_o` and `per_clk_en_o` are 0 and `imask_clr_o` = 1.
- R6: In halt, `int_irq_i` has no effect. Only `ext_irq_i` or `sys_reset_i` restarts the oscillator.
- R7: After a halt wake-up, exactly HALT_DELAY cycles show `osc_en_o` = 1 with both clock enables at 0. On the next cycle `resume_o` = 1 and, at full rate, `cpu_clk_en_o` = 1.
- R8: After a halt wake-up, `resume_reset_o` = 1 if `sys_reset_i` was seen at any cycle from the wake-up through the end of the count. Otherwise it is 0.
- R9: In run, `sys_reset_i` outranks every other input. The block stays in run at full rate whatever `slow_sel_i` is, and it ignores `wfi_i` and `halt_i`.
- R10: When `halt_i` and `wfi_i` are sampled together in run, the block enters halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| slow_sel_i | input | 1 | Selects half-rate CPU and peripheral clocking |
| wfi_i | input | 1 | One-cycle strobe requesting the wait state |
| halt_i | input | 1 | One-cycle strobe requesting the halt state |
| ext_irq_i | input | 1 | External interrupt request |
| int_irq_i | input | 1 | Internal peripheral interrupt request |
| sys_reset_i | input | 1 | Functional reset request, synchronous level |
| cpu_clk_en_o | output | 1 | Registered enable for the CPU clock gate |
| per_clk_en_o | output | 1 | Registered enable for the peripheral clock gate |
| osc_en_o | output | 1 | Oscillator enable |
| imask_clr_o | output | 1 | Forces the core's interrupt mask to 0 |
| resume_o | output | 1 | One-cycle pulse on return to run |
| resume_reset_o | output | 1 | With resume_o: 1 means fetch the reset vector, 0 means service the interrupt |

## Verification
The assertions assume that the mode strobes only arrive while the clocks are running and that `slow_sel_i` stays stable across the pair of cycles that the slow-gap property inspects. The stimulus keeps to this by driving strobes for one cycle in run only. It changes the slow bit only between scenarios and drives every input a few nanoseconds after the rising edge. The halt stabilization window is checked with a counter in the checker and not with a deep delay, because its length is a parameter.

// File: rtl/pmcc_pkg.sv
package pmcc_pkg;
   typedef enum logic [1:0] {
      PM_RUN  = 2'd0,
      PM_WAIT = 2'd1,
      PM_HALT = 2'd2,
      PM_STAB = 2'd3
   } pm_state_e;
endpackage

// File: rtl/pmcc_rate_div.sv
module pmcc_rate_div #(
   parameter bit SLOW_SUPPORT = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic slow_i,
   output logic tick_o
);
   generate
      if (SLOW_SUPPORT) begin : g_half
         logic ph_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     ph_q <= 1'b0;
            else if (clr_i)  ph_q <= 1'b0;
            else             ph_q <= ~ph_q;
         end
         assign tick_o = ~slow_i | ph_q;
      end else begin : g_full
         logic unused_in;
         assign unused_in = clr_i ^ slow_i ^ clk_i ^ rst_ni;
         assign tick_o    = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/pmcc_stab_timer.sv
module pmcc_stab_timer #(
   parameter int HALT_DELAY = 4096
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic run_i,
   output logic done_o
);
   localparam int CW = (HALT_DELAY > 2) ? $clog2(HALT_DELAY) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALT_DELAY - 1);

   generate
      if (HALT_DELAY < 2) begin : g_bad_delay
         $fatal(1, "pmcc_stab_timer: HALT_DELAY must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q <= '0;
      else if (start_i)  cnt_q <= '0;
      else if (run_i)    cnt_q <= cnt_q + 1'b1;
   end

   assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/pmcc_mode_fsm.sv
module pmcc_mode_fsm
   import pmcc_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic wfi_i,
   input  logic halt_i,
   input  logic ext_irq_i,
   input  logic int_irq_i,
   input  logic sys_reset_i,
   input  logic tick_i,
   input  logic timer_done_i,
   output logic timer_start_o,
   output logic timer_run_o,
   output logic cpu_clk_en_o,
   output logic per_clk_en_o,
   output logic osc_en_o,
   output logic imask_clr_o,
   output logic resume_o,
   output logic resume_reset_o
);
   pm_state_e st_q, st_d;
   logic      rflag_q, rflag_d;
   logic      back_to_run, cause_reset;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         PM_RUN: begin
            if (sys_reset_i)   st_d = PM_RUN;
            else if (halt_i)   st_d = PM_HALT;
            else if (wfi_i)    st_d = PM_WAIT;
         end
         PM_WAIT: if (sys_reset_i || ext_irq_i || int_irq_i) st_d = PM_RUN;
         PM_HALT: if (sys_reset_i || ext_irq_i)              st_d = PM_STAB;
         PM_STAB: if (timer_done_i)                          st_d = PM_RUN;
         default: st_d = PM_RUN;
      endcase
   end

   always_comb begin
      unique case (st_q)
         PM_HALT: rflag_d = sys_reset_i;
         PM_STAB: rflag_d = rflag_q | sys_reset_i;
         default: rflag_d = 1'b0;
      endcase
   end

   assign back_to_run   = (st_q != PM_RUN) && (st_d == PM_RUN);
   assign cause_reset   = (st_q == PM_WAIT) ? sys_reset_i : (rflag_q | sys_reset_i);
   assign timer_start_o = (st_q == PM_HALT) && (st_d == PM_STAB);
   assign timer_run_o   = (st_q == PM_STAB);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q           <= PM_RUN;
         rflag_q        <= 1'b0;
         cpu_clk_en_o   <= 1'b1;
         per_clk_en_o   <= 1'b1;
         osc_en_o       <= 1'b1;
         imask_clr_o    <= 1'b0;
         resume_o       <= 1'b0;
         resume_reset_o <= 1'b0;
      end else begin
         st_q           <= st_d;
         rflag_q        <= rflag_d;
         cpu_clk_en_o   <= (st_d == PM_RUN) && tick_i;
         per_clk_en_o   <= ((st_d == PM_RUN) || (st_d == PM_WAIT)) && tick_i;
         osc_en_o       <= (st_d != PM_HALT);
         imask_clr_o    <= (st_d != PM_RUN);
         resume_o       <= back_to_run;
         resume_reset_o <= back_to_run && cause_reset;
      end
   end
endmodule

// File: rtl/pmcc_top.sv
module pmcc_top #(
   parameter int HALT_DELAY   = 4096,
   parameter bit SLOW_SUPPORT = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic slow_sel_i,
   input  logic wfi_i,
   input  logic halt_i,
   input  logic ext_irq_i,
   input  logic int_irq_i,
   input  logic sys_reset_i,
   output logic cpu_clk_en_o,
   output logic per_clk_en_o,
   output logic osc_en_o,
   output logic imask_clr_o,
   output logic resume_o,
   output logic resume_reset_o
);
   logic slow_eff, tick, t_start, t_run, t_done;

   assign slow_eff = slow_sel_i & ~sys_reset_i;

   pmcc_rate_div #(.SLOW_SUPPORT(SLOW_SUPPORT)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (sys_reset_i),
      .slow_i (slow_eff),
      .tick_o (tick)
   );

   pmcc_stab_timer #(.HALT_DELAY(HALT_DELAY)) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (t_start),
      .run_i   (t_run),
      .done_o  (t_done)
   );

   pmcc_mode_fsm u_fsm (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .wfi_i          (wfi_i),
      .halt_i         (halt_i),
      .ext_irq_i      (ext_irq_i),
      .int_irq_i      (int_irq_i),
      .sys_reset_i    (sys_reset_i),
      .tick_i         (tick),
      .timer_done_i   (t_done),
      .timer_start_o  (t_start),
      .timer_run_o    (t_run),
      .cpu_clk_en_o   (cpu_clk_en_o),
      .per_clk_en_o   (per_clk_en_o),
      .osc_en_o       (osc_en_o),
      .imask_clr_o    (imask_clr_o),
      .resume_o       (resume_o),
      .resume_reset_o (resume_reset_o)
   );
endmodule

// File: rtl/pmcc_checker.sv
module pmcc_checker #(
   parameter int HALT_DELAY = 4096
) (
   input logic clk_i,
   input logic rst_ni,
   input logic slow_sel_i,
   input logic halt_i,
   input logic ext_irq_i,
   input logic sys_reset_i,
   input logic cpu_clk_en_o,
   input logic osc_en_o,
   input logic imask_clr_o,
   input logic resume_o,
   input logic resume_reset_o
);
   int   win_cnt;
   logic win_armed;
   logic osc_prev;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         win_cnt   <= 0;
         win_armed <= 1'b0;
         osc_prev  <= 1'b1;
      end else begin
         osc_prev <= osc_en_o;
         if (osc_en_o && !osc_prev) begin
            win_cnt   <= 1;
            win_armed <= 1'b1;
         end else if (resume_o) begin
            win_armed <= 1'b0;
         end else if (win_armed) begin
            win_cnt <= win_cnt + 1;
         end
      end
   end

   // R5: the CPU clock never ticks without the oscillator
   a_r5_cpu_needs_osc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_clk_en_o |-> osc_en_o);

   // R5: the oscillator only stops after a halt request
   a_r5_halt_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(osc_en_o) |-> $past(halt_i));

   // R3: forcing the mask open comes with the CPU stopped
   a_r3_mask_cpu_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      imask_clr_o |-> !cpu_clk_en_o);

   // R6: with the oscillator off, only external interrupt or reset wakes it
   a_r6_int_no_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!osc_en_o && !ext_irq_i && !sys_reset_i) |=> !osc_en_o);

   // R2: at half rate the CPU enable never stays high two cycles in a row
   a_r2_slow_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cpu_clk_en_o && slow_sel_i && !sys_reset_i && $past(slow_sel_i) && !$past(sys_reset_i))
      |=> !cpu_clk_en_o);

   // R4: resume is a single-cycle pulse and releases the mask
   a_r4_resume_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      resume_o |=> !resume_o);
   a_r4_resume_unmasks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      resume_o |-> !imask_clr_o);

   // R8: the vector choice is only given together with resume
   a_r8_vector_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
      resume_reset_o |-> resume_o);

   // R7: stabilization window after a halt wake lasts HALT_DELAY cycles
   a_r7_stab_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (resume_o && win_armed) |-> (win_cnt == HALT_DELAY));
endmodule

bind pmcc_top pmcc_checker #(.HALT_DELAY(HALT_DELAY)) u_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .slow_sel_i     (slow_sel_i),
   .halt_i         (halt_i),
   .ext_irq_i      (ext_irq_i),
   .sys_reset_i    (sys_reset_i),
   .cpu_clk_en_o   (cpu_clk_en_o),
   .osc_en_o       (osc_en_o),
   .imask_clr_o    (imask_clr_o),
   .resume_o       (resume_o),
   .resume_reset_o (resume_reset_o)
);

// File: tb/pmcc_top_test.sv
module pmcc_top_test;
   localparam int DLY = 4096;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic slow = 1'b0, wfi = 1'b0, hlt = 1'b0, eirq = 1'b0, iirq = 1'b0, srst = 1'b0;
   logic cpu_en, per_en, osc_en, imask, resume, res_rst;

   int vectors = 0;
   int miscompares = 0;

   always #10 clk = ~clk;

   pmcc_top #(.HALT_DELAY(DLY)) uut (
      .clk_i(clk), .rst_ni(rst_n), .slow_sel_i(slow), .wfi_i(wfi), .halt_i(hlt),
      .ext_irq_i(eirq), .int_irq_i(iirq), .sys_reset_i(srst),
      .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en), .osc_en_o(osc_en),
      .imask_clr_o(imask), .resume_o(resume), .resume_reset_o(res_rst)
   );

   task automatic tick();
      @(posedge clk);
      #5;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      int ones, prev, n;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1: reset state
      chk("R1 cpu after reset", cpu_en, 1);
      chk("R1 per after reset", per_en, 1);
      chk("R1 osc after reset", osc_en, 1);
      chk("R1 mask after reset", imask, 0);
      chk("R1 resume after reset", resume, 0);
      chk("R1 vector after reset", res_rst, 0);
      for (int i = 0; i < 8; i++) begin
         tick();
         chk("R1 full rate cpu", cpu_en, 1);
         chk("R1 full rate per", per_en, 1);
      end

      // R2: half rate
      slow = 1'b1;
      tick();
      ones = 0; prev = 0;
      for (int i = 0; i < 16; i++) begin
         tick();
         ones += cpu_en;
         chk("R2 per equals cpu", per_en, cpu_en);
         if (prev == 1) chk("R2 no back-to-back", cpu_en, 0);
         prev = cpu_en;
      end
      chk("R2 ones in 16 cycles", ones, 8);

      // R9: reset outranks slow and mode strobes
      srst = 1'b1;
      for (int i = 0; i < 4; i++) begin
         wfi = (i == 1); hlt = (i == 2);
         tick();
         chk("R9 full rate under reset", cpu_en, 1);
         chk("R9 osc under reset", osc_en, 1);
         chk("R9 no mask under reset", imask, 0);
      end
      wfi = 1'b0; hlt = 1'b0; srst = 1'b0; slow = 1'b0;
      tick();

      // R3/R4: wait entry and each wake source
      for (int src = 0; src < 3; src++) begin
         wfi = 1'b1;
         tick();
         wfi = 1'b0;
         chk("R3 cpu stopped", cpu_en, 0);
         chk("R3 per running", per_en, 1);
         chk("R3 osc on", osc_en, 1);
         chk("R3 mask forced", imask, 1);
         for (int i = 0; i < 5; i++) begin
            tick();
            chk("R3 still waiting", cpu_en, 0);
            chk("R4 no early resume", resume, 0);
         end
         eirq = (src == 0); iirq = (src == 1); srst = (src == 2);
         tick();
         eirq = 1'b0; iirq = 1'b0; srst = 1'b0;
         chk("R4 resume pulse", resume, 1);
         chk("R4 vector choice", res_rst, (src == 2) ? 1 : 0);
         chk("R4 cpu back", cpu_en, 1);
         chk("R4 mask released", imask, 0);
         tick();
         chk("R4 pulse ends", resume, 0);
      end

      // R3: peripherals keep the half rate in wait
      slow = 1'b1;
      wfi = 1'b1;
      tick();
      wfi = 1'b0;
      ones = 0;
      for (int i = 0; i < 8; i++) begin
         tick();
         ones += per_en;
         chk("R3 cpu off at half rate", cpu_en, 0);
      end
      chk("R3 per ones in wait", ones, 4);
      iirq = 1'b1;
      tick();
      iirq = 1'b0;
      slow = 1'b0;
      tick();
      tick();

      // R5..R8, R10: halt, wake and stabilization
      for (int c = 0; c < 4; c++) begin
         hlt = 1'b1;
         wfi = (c == 3);
         tick();
         hlt = 1'b0; wfi = 1'b0;
         chk((c == 3) ? "R10 halt wins over wait" : "R5 osc off", osc_en, 0);
         chk("R5 cpu off", cpu_en, 0);
         chk("R5 per off", per_en, 0);
         chk("R5 mask forced", imask, 1);
         iirq = 1'b1;
         for (int i = 0; i < 10; i++) begin
            tick();
            chk("R6 internal irq ignored", osc_en, 0);
         end
         iirq = 1'b0;
         eirq = (c != 2); srst = (c == 2);
         tick();
         eirq = 1'b0; srst = 1'b0;
         chk("R6 osc restarted", osc_en, 1);
         chk("R7 cpu held during count", cpu_en, 0);
         n = 1;
         while (!cpu_en && n < DLY + 10) begin
            srst = (c == 1 && n == 100);
            tick();
            if (!cpu_en) n++;
         end
         srst = 1'b0;
         chk("R7 stabilization length", n, DLY);
         chk("R7 resume after count", resume, 1);
         chk("R8 vector after halt", res_rst, (c == 1 || c == 2) ? 1 : 0);
         tick();
         chk("R7 per running again", per_en, 1);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule